// File: doc/BRIEF.md
# Watchdog Timer with Tick Prescaler

A bus-mapped watchdog for a system that must restart itself when its software stops running. A prescaler divides the block clock into a slow tick. The nominal setting is one tick per microsecond, which takes a divider of 12 from a 12 MHz reference. On each tick the 24-bit watchdog count drops by two, so software loads twice the wanted number of microseconds. When the count reaches zero, the block raises a one-cycle reset request toward the power manager. Software can also raise that request at once through a trigger bit.

Three debug-halt inputs can freeze the count. Each one only takes effect while its own pause bit is set. A cause register records whether the last request came from an expiry or from a software trigger. Eight scratch words hold software state across a restart. The cause register and the scratch words are cleared only by the power-on reset `por_n`. The ordinary reset `rst_n`, which the watchdog's own request normally drives, leaves them intact.

Register map (word addresses): 0 control, 1 reload, 2 cause, 3 tick setup, 4 to 11 scratch words.

Top module: `wdt_top`

## Requirements
- R1: Tick setup register (address 3) holds a divider in bits [8:0] and a run bit in bit 9. With the run bit set and divider N ≥ 1, exactly one tick occurs every N clocks. With the run bit clear or N = 0, no tick occurs and the count stays frozen.
- R2: Each tick that is allowed to count lowers the count by 2, never below 0. An odd value goes 1 → 0.
- R3: A write to address 1 replaces the count on that same clock edge with wdata[23:0]; bits above 23 are ignored. The count is read back in control bits [23:0].
- R4: While control bit 30 (enable) is clear, the count does not change except by a reload, and no expiry occurs.
- R5: Control bits 24, 25 and 26 are pause enables for dbg_halt[0], dbg_halt[1] and dbg_halt[2]. Counting stops only while a pause bit is set and its matching halt input is high.
- R6: The decrement that brings the count to 0 makes reset_req high for exactly one cycle, on the same edge. The count then stays at 0 with no further request until it is reloaded.
- R7: A control write with wdata[31] = 1 makes reset_req high for one cycle, beginning at that write's edge. Control bit 31 always reads 0.
- R8: Cause register (address 2): bit 0 is expiry and bit 1 is software trigger. Each request replaces both bits with its own causes. Only por_n clears them; rst_n does not.
- R9: The scratch words at addresses 4 to 11 are read/write 32-bit registers. They keep their value through rst_n and are cleared by por_n.
- R10: Either reset clears the control register, tick setup, count, prescaler and reset_req to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler reference |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | Ordinary reset, active low, keeps cause and scratch |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dbg_halt | input | 3 | Debug-halt inputs, one per pause bit |
| reset_req | output | 1 | One-cycle restart request |

## Verification
The hardest case to reach is the exact cycle of expiry, because the prescaler phase is hidden from the ports. The stimulus removes that uncertainty by setting the divider to 1, so that every clock is a tick and each edge lowers the count by exactly two. The divider ratio itself is measured over a window that is a whole multiple of the divider, which gives a fixed decrement whatever the starting phase. Survival across the ordinary reset is shown by first writing the scratch words and the cause bits, then pulsing rst_n, reading them back, and finally pulsing por_n.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_RELOAD = 1;
  localparam int ADR_CAUSE  = 2;
  localparam int ADR_TICK   = 3;
  localparam int ADR_SCR0   = 4;

  localparam int CTRL_PAUSE_LO = 24;
  localparam int CTRL_EN_BIT   = 30;
  localparam int CTRL_KICK_BIT = 31;

  localparam int CAUSE_EXPIRE = 0;
  localparam int CAUSE_KICK   = 1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase;
  logic             active;
  logic             wrap;

  assign active = run && (div != '0);
  assign wrap   = active && (phase >= div - DIV_W'(1));
  assign tick   = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (!active) phase <= '0;
    else if (wrap)    phase <= '0;
    else              phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 24,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_en,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  function automatic logic [CNT_W-1:0] sat_down(input logic [CNT_W-1:0] c);
    return (c <= STEP_V) ? '0 : c - STEP_V;
  endfunction

  assign expire = step_en && !load && (count != '0) && (count <= STEP_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         count <= '0;
    else if (load)                      count <= load_val;
    else if (step_en && count != '0)    count <= sat_down(count);
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int NUM_SCRATCH = 8,
  parameter int DIV_W       = 9,
  parameter int CNT_W       = 24
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [2:0]        dbg_halt,
  output logic              reset_req
);
  localparam int TICK_RUN_BIT = DIV_W;

  logic              sys_rst_n;
  logic              wr;
  logic              load_evt;
  logic              kick_evt;
  logic              expire_evt;
  logic              halted;
  logic              tick;
  logic              step_en;
  logic              ctrl_en;
  logic [2:0]        pause;
  logic              tick_run;
  logic [DIV_W-1:0]  tick_div;
  logic [1:0]        cause;
  logic [CNT_W-1:0]  count;
  logic [31:0]       scratch [NUM_SCRATCH];
  logic              unused_wdata;

  assign sys_rst_n    = por_n & rst_n;
  assign wr           = bus_valid & bus_write;
  assign load_evt     = wr && (bus_addr == ADDR_W'(ADR_RELOAD));
  assign kick_evt     = wr && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[CTRL_KICK_BIT];
  assign halted       = |(pause & dbg_halt);
  assign step_en      = ctrl_en && tick && !halted;
  assign unused_wdata = ^bus_wdata[29:27];

  wdt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk  (clk),
    .rst_n(sys_rst_n),
    .run  (tick_run),
    .div  (tick_div),
    .tick (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .STEP(2)) u_cnt (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .load    (load_evt),
    .load_val(bus_wdata[CNT_W-1:0]),
    .step_en (step_en),
    .count   (count),
    .expire  (expire_evt)
  );

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ctrl_en   <= 1'b0;
      pause     <= '0;
      tick_run  <= 1'b0;
      tick_div  <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= expire_evt | kick_evt;
      if (wr && bus_addr == ADDR_W'(ADR_CTRL)) begin
        ctrl_en <= bus_wdata[CTRL_EN_BIT];
        pause   <= bus_wdata[CTRL_PAUSE_LO +: 3];
      end
      if (wr && bus_addr == ADDR_W'(ADR_TICK)) begin
        tick_run <= bus_wdata[TICK_RUN_BIT];
        tick_div <= bus_wdata[DIV_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                       cause <= '0;
    else if (expire_evt || kick_evt)  cause <= {kick_evt, expire_evt};
  end

  for (genvar i = 0; i < NUM_SCRATCH; i++) begin : g_scr
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) scratch[i] <= '0;
      else if (wr && bus_addr == ADDR_W'(ADR_SCR0 + i)) scratch[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL)) begin
      bus_rdata[CNT_W-1:0]           = count;
      bus_rdata[CTRL_PAUSE_LO +: 3]  = pause;
      bus_rdata[CTRL_EN_BIT]         = ctrl_en;
    end else if (bus_addr == ADDR_W'(ADR_CAUSE)) begin
      bus_rdata[1:0] = cause;
    end else if (bus_addr == ADDR_W'(ADR_TICK)) begin
      bus_rdata[DIV_W-1:0]   = tick_div;
      bus_rdata[TICK_RUN_BIT] = tick_run;
    end else begin
      for (int i = 0; i < NUM_SCRATCH; i++)
        if (bus_addr == ADDR_W'(ADR_SCR0 + i)) bus_rdata = scratch[i];
    end
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             reset_req,
  input logic             expire_evt,
  input logic             kick_evt,
  input logic             load_evt,
  input logic             ctrl_en,
  input logic [1:0]       cause,
  input logic [CNT_W-1:0] count
);
  // R6
  expire_req_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    expire_evt |=> reset_req && cause[0] && (count == '0));

  // R7
  kick_req_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    kick_evt |=> reset_req && cause[1]);

  // R6
  req_source_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reset_req |-> $past(expire_evt || kick_evt));

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (!load_evt && !ctrl_en) |=> $stable(count));

  // R2
  no_rise_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !load_evt |=> (count <= $past(count)) && (($past(count) - count) <= CNT_W'(2)));
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .reset_req (reset_req),
  .expire_evt(expire_evt),
  .kick_evt  (kick_evt),
  .load_evt  (load_evt),
  .ctrl_en   (ctrl_en),
  .cause     (cause),
  .count     (count)
);

// File: tb/wdt_top_test.sv
module wdt_top_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  dbg_halt = '0;
  logic        reset_req;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  localparam logic [31:0] EN = 32'h4000_0000;

  always #2 clk = ~clk;

  wdt_top uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .reset_req(reset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); check("R10 ctrl after reset", d, 0);
    rd(3, d); check("R10 tick after reset", d, 0);
    rd(2, d); check("R8 cause after reset", d, 0);
    rd(4, d); check("R9 scratch after reset", d, 0);
    check("R10 req after reset", 32'(reset_req), 0);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    wr(3, 32'h201);
    wr(0, EN);
    wr(1, 32'hFF00_0123);
    rd(0, d); check("R3 reload value", d, EN | 32'h123);
    edges(1);
    rd(0, d); check("R2 one step", d, EN | 32'h121);
    wr(1, 10);
    edges(4);
    rd(0, d); check("R2 four steps", d, EN | 32'd2);
    check("R6 no early req", 32'(reset_req), 0);
    edges(1);
    rd(0, d); check("R6 count at zero", d, EN);
    check("R6 req raised", 32'(reset_req), 1);
    rd(2, d); check("R8 expiry cause", d, 32'h1);
    edges(1);
    check("R6 req one cycle", 32'(reset_req), 0);
    edges(3);
    rd(0, d); check("R6 stays zero", d, EN);
    check("R6 no repeat req", 32'(reset_req), 0);
    wr(1, 5);
    edges(2);
    rd(0, d); check("R2 odd value", d, EN | 32'd1);
    edges(1);
    rd(0, d); check("R2 saturate to zero", d, EN);
    check("R6 req from odd", 32'(reset_req), 1);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    dbg_halt = 3'b001;
    wr(0, EN | 32'h0100_0000);
    wr(1, 100);
    edges(5);
    rd(0, d); check("R5 paused by halt0", d[23:0], 100);
    dbg_halt = 3'b010;
    edges(5);
    rd(0, d); check("R5 halt1 without pause bit", d[23:0], 90);
    wr(0, EN | 32'h0400_0000);
    dbg_halt = 3'b100;
    wr(1, 100);
    edges(5);
    rd(0, d); check("R5 paused by halt2", d[23:0], 100);
    dbg_halt = 3'b000;
    edges(5);
    rd(0, d); check("R5 resume", d[23:0], 90);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    wr(0, 0);
    wr(1, 50);
    edges(6);
    rd(0, d); check("R4 disabled hold", d, 50);
    check("R4 no req", 32'(reset_req), 0);
    wr(0, EN);
    wr(3, 32'h001);
    wr(1, 50);
    edges(6);
    rd(0, d); check("R1 tick run bit clear", d[23:0], 50);
    wr(3, 32'h200);
    wr(1, 50);
    edges(6);
    rd(0, d); check("R1 divider zero", d[23:0], 50);
    wr(0, 0);
    wr(1, 32'hFFFF_FFFF);
    rd(0, d); check("R3 max reload", d, 32'h00FF_FFFF);
  endtask

  task automatic t_divider();
    logic [31:0] a, b;
    wr(0, EN);
    wr(3, 32'h204);
    wr(1, 1000);
    rd(0, a);
    edges(40);
    rd(0, b);
    check("R1 divide by 4", a - b, 20);
    wr(3, 32'h20C);
    wr(1, 1000);
    rd(0, a);
    edges(48);
    rd(0, b);
    check("R1 divide by 12", a - b, 8);
  endtask

  task automatic t_kick_and_resets();
    logic [31:0] d;
    wr(0, 32'h8000_0000);
    check("R7 trigger req", 32'(reset_req), 1);
    rd(0, d); check("R7 trigger bit reads 0", d[31:24], 0);
    rd(2, d); check("R8 trigger cause", d, 32'h2);
    edges(1);
    check("R7 req one cycle", 32'(reset_req), 0);
    for (int i = 0; i < 8; i++) wr(4 + i, 32'hA500_0000 + 32'(i * 32'h111));
    for (int i = 0; i < 8; i++) begin
      rd(4 + i, d); check("R9 scratch readback", d, 32'hA500_0000 + 32'(i * 32'h111));
    end
    wr(3, 32'h203);
    wr(0, EN);
    wr(1, 77);
    @(negedge clk); rst_n = 1'b0;
    edges(2); rst_n = 1'b1;
    edges(1);
    rd(0, d); check("R10 ctrl cleared by rst_n", d, 0);
    rd(3, d); check("R10 tick cleared by rst_n", d, 0);
    rd(2, d); check("R8 cause kept by rst_n", d, 32'h2);
    for (int i = 0; i < 8; i++) begin
      rd(4 + i, d); check("R9 scratch kept by rst_n", d, 32'hA500_0000 + 32'(i * 32'h111));
    end
    @(negedge clk); por_n = 1'b0;
    edges(2); por_n = 1'b1;
    edges(1);
    rd(2, d); check("R8 cause cleared by por_n", d, 0);
    rd(7, d); check("R9 scratch cleared by por_n", d, 0);
  endtask

  initial begin
    edges(3);
    por_n = 1'b1;
    edges(2);
    t_reset();
    t_expire();
    t_pause();
    t_gating();
    t_divider();
    t_kick_and_resets();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule